// File: doc/BRIEF.md
# Network Port Interrupt Status Aggregator

This block gathers interrupt requests raised by the ports of up to five network module slots. It keeps them in two 16-bit status words that a CPU can read, and it folds them into one interrupt line. Each request strobe carries a slot index and a port index. The block turns that pair into a single bit at a fixed position in one of the two status words. The bits are active-low: a 0 marks a port that is waiting for service, and a 1 marks a port that is quiet.

The two words do not split the slots evenly. Slot 0 owns a full byte of the first word. Slots 1 to 4 each own one nibble of the second word. Software reads either word through a small register port addressed by byte offset. The read data is combinational and has no side effects. The combined interrupt output is registered.

The strobes are single-cycle control pulses. There is no back-pressure, because every request is accepted in the cycle it is presented. For the same reason the block uses plain control pins and no valid/ready handshake.

Top module: `net_irq_agg`

## Requirements
- R1: After reset, both status words read 0xFFFF and `irq_o` is 0.
- R2: An assert strobe (`req_set_i`) clears the selected status bit to 0 at the next clock edge. A withdraw strobe (`req_clr_i`) sets the selected bit back to 1 at the next clock edge. No other bit changes.
- R3: Slot 0 maps port p (0 to 7) to bit p of the first status word.
- R4: Slot s (1 to 4) maps port p (0 to 3) to bit 4*(s-1)+p of the second status word.
- R5: A strobe whose slot is above 4, or whose port is outside its slot's field (above 7 for slot 0, above 3 for slots 1 to 4), changes no bit.
- R6: If an assert and a withdraw hit the same bit in the same cycle, the bit becomes 0. If they hit different bits in the same cycle, both take effect.
- R7: `irq_o` is 1 exactly when some status bit was 0 after the previous clock edge. It follows a status change one clock later.
- R8: `rd_data_o` shows the first word when `rd_addr_i` is 0x20 and the second word when it is 0x22, in the same cycle. Every other offset reads 0xFFFF.
- R9: Reading does not alter the status words. They change only through the request strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_i | input | 1 | Assert strobe for one port request |
| req_set_slot_i | input | 3 | Slot index of the assert strobe |
| req_set_port_i | input | 3 | Port index of the assert strobe |
| req_clr_i | input | 1 | Withdraw strobe for one port request |
| req_clr_slot_i | input | 3 | Slot index of the withdraw strobe |
| req_clr_port_i | input | 3 | Port index of the withdraw strobe |
| rd_addr_i | input | 8 | Byte offset of the register read |
| rd_data_o | output | 16 | Read data |
| irq_o | output | 1 | Combined interrupt, high while any request is pending |

## Verification
The bench targets the field edges that an off-by-one mapping would get wrong. These are slot 0 port 7, slot 4 port 3, and the nibble seams between slots 1 to 4. A wrong mapping would leak a bit into a neighbour's field. The bench also drives ports and slots just past their fields, which a design without range checks would wrap into another slot's bits. It collides an assert with a withdraw on one bit, where the wrong priority would leave the bit at 1 and miss a pending request. It checks the one-cycle lag of `irq_o`, which an unregistered or doubly registered output would miss. It also reads unmapped offsets, which must not alias onto a status word.

// File: rtl/niq_pkg.sv
package niq_pkg;
  localparam int REG_W     = 16;
  localparam int FLAT_W    = 2 * REG_W;
  localparam int SLOT_W    = 3;
  localparam int PORT_W    = 3;
  localparam int ADDR_W    = 8;
  localparam int NUM_SLOTS = 5;
  localparam int NIB_W     = 4;

  // Flat bit index of port 0 of a slot; bits [REG_W-1:0] are word A, upper half word B.
  function automatic int slot_lo(input int s);
    return (s == 0) ? 0 : REG_W + NIB_W * (s - 1);
  endfunction

  function automatic int slot_width(input int s);
    return (s == 0) ? 2 * NIB_W : NIB_W;
  endfunction
endpackage

// File: rtl/niq_bit_decode.sv
module niq_bit_decode
  import niq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PORT_W-1:0] port,
  output logic [FLAT_W-1:0] vec
);
  logic [NUM_SLOTS-1:0][FLAT_W-1:0] per_slot;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int LO  = slot_lo(g);
    localparam int WID = slot_width(g);
    always_comb begin
      per_slot[g] = '0;
      if (en && (int'(slot) == g) && (int'(port) < WID))
        per_slot[g] = FLAT_W'(1) << (LO + int'(port));
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_SLOTS; i++) vec = vec | per_slot[i];
  end

  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec));
  assert_bad_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot) >= NUM_SLOTS) |-> (vec == '0));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (vec == '0));
endmodule

// File: rtl/niq_status_bank.sv
module niq_status_bank
  import niq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] set_vec,
  input  logic [FLAT_W-1:0] clr_vec,
  output logic [FLAT_W-1:0] status,
  output logic              irq
);
  logic [FLAT_W-1:0] status_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '1;
      irq_q    <= 1'b0;
    end else begin
      // assert wins over withdraw on the same bit
      status_q <= (status_q | clr_vec) & ~set_vec;
      irq_q    <= ~&status_q;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == '0));
  assert_clr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == $past(clr_vec & ~set_vec)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(status_q));
  assert_irq_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '1) |=> irq_q);
  assert_irq_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '1) |=> !irq_q);
endmodule

// File: rtl/niq_read_mux.sv
module niq_read_mux
  import niq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OFS_A = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_B = 8'h22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLAT_W-1:0] status,
  output logic [REG_W-1:0]  data
);
  always_comb begin
    if (addr == OFS_A)      data = status[REG_W-1:0];
    else if (addr == OFS_B) data = status[FLAT_W-1:REG_W];
    else                    data = '1;
  end
endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg
  import niq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_set_i,
  input  logic [SLOT_W-1:0] req_set_slot_i,
  input  logic [PORT_W-1:0] req_set_port_i,
  input  logic              req_clr_i,
  input  logic [SLOT_W-1:0] req_clr_slot_i,
  input  logic [PORT_W-1:0] req_clr_port_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [FLAT_W-1:0] set_vec, clr_vec, status;

  niq_bit_decode u_set_dec (
    .clk(clk), .rst_n(rst_n), .en(req_set_i),
    .slot(req_set_slot_i), .port(req_set_port_i), .vec(set_vec));

  niq_bit_decode u_clr_dec (
    .clk(clk), .rst_n(rst_n), .en(req_clr_i),
    .slot(req_clr_slot_i), .port(req_clr_port_i), .vec(clr_vec));

  niq_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status(status), .irq(irq_o));

  niq_read_mux #(.OFS_A(8'h20), .OFS_B(8'h22)) u_rd (
    .addr(rd_addr_i), .status(status), .data(rd_data_o));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr_i != 8'h20) && (rd_addr_i != 8'h22)) |-> (rd_data_o == 16'hFFFF));
endmodule

// File: tb/net_irq_agg_tb.sv
module net_irq_agg_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       set_en = 0, clr_en = 0;
  logic [2:0] set_slot = 0, set_port = 0, clr_slot = 0, clr_port = 0;
  logic [7:0] rd_addr = 0;
  logic [15:0] rd_data;
  logic       irq;
  int checks = 0, fails = 0;
  logic [15:0] exp_a = 16'hFFFF, exp_b = 16'hFFFF;
  logic        done = 0;

  always #4 clk = ~clk;

  net_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_set_i(set_en), .req_set_slot_i(set_slot), .req_set_port_i(set_port),
    .req_clr_i(clr_en), .req_clr_slot_i(clr_slot), .req_clr_port_i(clr_port),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

  // Requirement mapping (R3, R4, R5): bits 15:0 word A, 31:16 word B
  function automatic logic [31:0] bit_of(input int s, input int p);
    if (s == 0 && p < 8) return 32'h1 << p;
    if (s >= 1 && s <= 4 && p < 4) return 32'h1 << (16 + 4 * (s - 1) + p);
    return 32'h0;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    rd_addr = 8'h20; #1; chk(rd_data, exp_a, req);
    rd_addr = 8'h22; #1; chk(rd_data, exp_b, req);
  endtask

  // One strobe cycle at a negedge; model update; check words and lagging irq.
  task automatic op(input bit se, input int ss, input int sp,
                    input bit ce, input int cs, input int cp, input string req);
    logic [31:0] cur, sv, cv;
    logic        prev_irq;
    cur = {exp_b, exp_a};
    prev_irq = (cur != 32'hFFFF_FFFF);
    set_en = se; set_slot = 3'(ss); set_port = 3'(sp);
    clr_en = ce; clr_slot = 3'(cs); clr_port = 3'(cp);
    @(posedge clk); @(negedge clk);
    set_en = 0; clr_en = 0;
    sv = se ? bit_of(ss, sp) : 32'h0;
    cv = ce ? bit_of(cs, cp) : 32'h0;
    cur = (cur | cv) & ~sv;
    exp_a = cur[15:0]; exp_b = cur[31:16];
    chk_regs(req);
    chk({15'h0, irq}, {15'h0, prev_irq}, "R7 lag");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_regs("R1 reset");
    chk({15'h0, irq}, 16'h0, "R1 irq");

    op(1, 0, 7, 0, 0, 0, "R3 slot0 port7");
    op(0, 0, 0, 0, 0, 0, "R7 settle");
    chk({15'h0, irq}, 16'h1, "R7 high");
    op(0, 0, 0, 1, 0, 7, "R2 withdraw");
    op(0, 0, 0, 0, 0, 0, "R7 settle");
    chk({15'h0, irq}, 16'h0, "R7 low");
    op(1, 4, 3, 0, 0, 0, "R4 slot4 port3");
    op(1, 1, 0, 0, 0, 0, "R4 slot1 port0");
    op(1, 2, 0, 0, 0, 0, "R4 slot2 seam");
    op(1, 5, 1, 0, 0, 0, "R5 bad slot");
    op(1, 1, 4, 0, 0, 0, "R5 bad port");
    op(0, 0, 0, 1, 7, 7, "R5 bad clear");
    op(1, 3, 2, 1, 3, 2, "R6 collision");
    op(1, 0, 1, 1, 4, 3, "R6 distinct");
    rd_addr = 8'h24; #1; chk(rd_data, 16'hFFFF, "R8 unmapped 24");
    rd_addr = 8'h21; #1; chk(rd_data, 16'hFFFF, "R8 unmapped 21");
    rd_addr = 8'h00; #1; chk(rd_data, 16'hFFFF, "R8 unmapped 00");
    for (int k = 0; k < 4; k++) begin
      rd_addr = 8'h20; @(negedge clk);
      rd_addr = 8'h22; @(negedge clk);
    end
    chk_regs("R9 reads idle");

    for (int n = 0; n < 400; n++) begin
      op(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
         1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
         "R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule